// File: doc/BRIEF.md
# Single-Wire Slave Bit Engine

This block is the lowest layer of the slave side of a single-wire, open-drain serial port. It watches a data line that idles high and is pulled low by the master, and it can pull the line low itself. Every falling edge starts a time slot. The block measures each slot with a counter that runs on the system clock, and it does one of three things with the slot:

- It decodes a master write slot into one received bit.
- It holds the line low during a read slot when the bit to return is 0.
- It recognises a very long low as a bus reset and answers that reset with a presence pulse.

Upper protocol layers see only single-cycle strobes. There is a reset strobe and a received-bit strobe with its value. For transmit, the upper layer holds a request with the bit to send, and the block acknowledges the request when the slot that carries the bit begins. Every time window is given in microseconds and converted to clock cycles through a clock-frequency parameter. The raw line passes through a synchroniser before the block uses it.

Top module: `wire1_slave_phy`

## Requirements
- R1: After reset, `lineDrvLow` is 0 and none of the strobes `txAck`, `rxValid` or `resetSeen` fires while the line stays idle high.
- R2: A falling edge with `txReq` low starts a write slot. The line is sampled `SAMPLE_US` (default 30 µs) after the synchronised falling edge. `rxValid` then pulses for one cycle, and `rxBit` is 1 if the line was high at the sample point and 0 if it was low.
- R3: A falling edge with `txReq` high and `txBit` = 0 starts a read slot. `txAck` pulses for one cycle at that edge. The block holds the line low from within three cycles of the falling edge for `RD_HOLD_US` (default 30 µs), so a master that samples 13 µs into the slot reads 0. It then releases the line.
- R4: A read slot with `txBit` = 1 is acknowledged with `txAck` and never drives the line, so the master reads 1. A read slot produces no `rxValid`.
- R5: The slot type is fixed at the falling edge. A `txReq` raised after the edge does not change the current slot: that slot stays a write slot, gets no `txAck` and no drive, and the request is served at the next falling edge.
- R6: A low that lasts `RST_US` (default 450 µs) from its falling edge produces exactly one `resetSeen` pulse. The sample taken inside that low has already been reported as a 0 bit.
- R7: After the rising edge that ends a reset, the block waits `PD_WAIT_US` (default 30 µs) and then drives the line low for `PD_LOW_US` (default 120 µs) as the presence pulse.
- R8: A low shorter than `RST_US` (for example 120 µs or 400 µs) gives no `resetSeen` and no presence pulse. It yields one received 0 bit.
- R9: Falling and rising edges that the master makes while the block waits to send presence are ignored. They produce no received bit, and the presence pulse still follows at its normal time.
- R10: The block drives the line only during a read slot carrying a 0 or during a presence pulse. It never drives during a write slot or while idle.
- R11: The strobes `txAck`, `rxValid` and `resetSeen` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Raw level of the open-drain data line |
| lineDrvLow | output | 1 | 1 = pull the data line low; 0 = release it |
| txReq | input | 1 | Upper layer has a bit to return in the next slot |
| txBit | input | 1 | Bit to return when `txReq` is high |
| txAck | output | 1 | One-cycle strobe: the pending bit was taken by a starting read slot |
| rxValid | output | 1 | One-cycle strobe: a write slot was decoded |
| rxBit | output | 1 | Value of the last decoded bit |
| resetSeen | output | 1 | One-cycle strobe: a bus reset low was detected |

## Verification
The hardest situation to reach from the ports is master activity inside the gap between the end of a reset low and the presence pulse. A plain master waits quietly for presence, so this case needs its own stimulus. The bench ends a reset and then pulses the line for a few cycles while the block is waiting to send presence. It then checks that no bit is reported and that presence still starts and lasts as specified. Random write slots with low times on either side of the sample point are mixed with random read slots. This exercises both slot types back to back. Directed lows of 120 µs and 400 µs test the boundary just below the reset threshold.

// File: rtl/w1p_pkg.sv
package w1p_pkg;

  // Slot phase of the bit engine
  typedef enum logic [2:0] {
    PH_IDLE,    // line high, waiting for a falling edge
    PH_WSLOT,   // write slot, waiting for the sample point
    PH_RSLOT,   // read slot, holding or not holding the line
    PH_LOWWAIT, // slot done, waiting for the line to rise (or reset)
    PH_RSTHI,   // reset recognised, waiting for the master to release
    PH_PDWAIT,  // gap before presence
    PH_PDDRV,   // presence pulse
    PH_PDREL    // presence released, waiting for the line to rise
  } phase_e;

  // Control to datapath strobes
  typedef struct packed {
    logic tmrClr;
    logic drvSet;
    logic drvClr;
    logic rxCap;
  } ctl_t;

  // Datapath to control status
  typedef struct packed {
    logic fall;
    logic rise;
    logic lineHi;
    logic atSample;
    logic atHold;
    logic atReset;
    logic atPdWait;
    logic atPdLow;
  } stat_t;

endpackage

// File: rtl/w1p_datapath.sv
module w1p_datapath
  import w1p_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_CYC  = 120,
  parameter int HOLD_CYC    = 120,
  parameter int RST_CYC     = 1800,
  parameter int PDW_CYC     = 120,
  parameter int PDL_CYC     = 480,
  parameter int TMR_W       = 11
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  lineIn,
  input  ctl_t  ctl,
  output stat_t st,
  output logic  lineDrvLow,
  output logic  rxValid,
  output logic  rxBit
);

  localparam logic [TMR_W-1:0] SAMPLE_END = TMR_W'(SAMPLE_CYC - 1);
  localparam logic [TMR_W-1:0] HOLD_END   = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] RST_END    = TMR_W'(RST_CYC - 1);
  localparam logic [TMR_W-1:0] PDW_END    = TMR_W'(PDW_CYC - 1);
  localparam logic [TMR_W-1:0] PDL_END    = TMR_W'(PDL_CYC - 1);
  localparam logic [TMR_W-1:0] TMR_MAX    = '1;

  // Synchroniser chain, idle high
  logic [SYNC_STAGES-1:0] syncQ;
  logic lineS;
  logic lineD;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= lineIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[i] <= 1'b1;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  assign lineS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) lineD <= 1'b1;
    else       lineD <= lineS;
  end

  // Slot timer, saturating
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (!rstN)             tmr <= '0;
    else if (ctl.tmrClr)   tmr <= '0;
    else if (tmr != TMR_MAX) tmr <= tmr + 1'b1;
  end

  // Open-drain pull-down register
  logic drvQ;

  always_ff @(posedge clk) begin
    if (!rstN)           drvQ <= 1'b0;
    else if (ctl.drvSet) drvQ <= 1'b1;
    else if (ctl.drvClr) drvQ <= 1'b0;
  end

  assign lineDrvLow = drvQ;

  // Received bit capture
  logic rxValidQ;
  logic rxBitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValidQ <= 1'b0;
      rxBitQ   <= 1'b1;
    end else begin
      rxValidQ <= ctl.rxCap;
      if (ctl.rxCap) rxBitQ <= lineS;
    end
  end

  assign rxValid = rxValidQ;
  assign rxBit   = rxBitQ;

  // Status toward control
  always_comb begin
    st          = '0;
    st.fall     = lineD & ~lineS;
    st.rise     = ~lineD & lineS;
    st.lineHi   = lineS;
    st.atSample = (tmr == SAMPLE_END);
    st.atHold   = (tmr == HOLD_END);
    st.atReset  = (tmr == RST_END);
    st.atPdWait = (tmr == PDW_END);
    st.atPdLow  = (tmr == PDL_END);
  end

  // R2
  rx_no_drv_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !lineDrvLow);

  // R6
  tmr_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmr == TMR_MAX && !ctl.tmrClr) |=> (tmr == TMR_MAX));

endmodule

// File: rtl/w1p_control.sv
module w1p_control
  import w1p_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  stat_t st,
  input  logic  txReq,
  input  logic  txBit,
  input  logic  drvActive,
  output ctl_t  ctl,
  output logic  txAck,
  output logic  resetSeen
);

  phase_e phase;
  phase_e phaseNxt;
  logic   rstHit;
  logic   resetSeenQ;

  always_comb begin
    ctl      = '0;
    phaseNxt = phase;
    txAck    = 1'b0;
    rstHit   = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (st.fall) begin
          ctl.tmrClr = 1'b1;
          if (txReq) begin
            txAck      = 1'b1;
            ctl.drvSet = ~txBit;
            phaseNxt   = PH_RSLOT;
          end else begin
            phaseNxt = PH_WSLOT;
          end
        end
      end
      PH_WSLOT: begin
        if (st.atSample) begin
          ctl.rxCap = 1'b1;
          phaseNxt  = PH_LOWWAIT;
        end
      end
      PH_RSLOT: begin
        if (st.atHold) begin
          ctl.drvClr = 1'b1;
          phaseNxt   = PH_LOWWAIT;
        end
      end
      PH_LOWWAIT: begin
        if (st.lineHi) begin
          phaseNxt = PH_IDLE;
        end else if (st.atReset) begin
          rstHit   = 1'b1;
          phaseNxt = PH_RSTHI;
        end
      end
      PH_RSTHI: begin
        if (st.rise) begin
          ctl.tmrClr = 1'b1;
          phaseNxt   = PH_PDWAIT;
        end
      end
      PH_PDWAIT: begin
        if (st.atPdWait) begin
          ctl.tmrClr = 1'b1;
          ctl.drvSet = 1'b1;
          phaseNxt   = PH_PDDRV;
        end
      end
      PH_PDDRV: begin
        if (st.atPdLow) begin
          ctl.drvClr = 1'b1;
          phaseNxt   = PH_PDREL;
        end
      end
      PH_PDREL: begin
        if (st.lineHi) phaseNxt = PH_IDLE;
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      resetSeenQ <= 1'b0;
    end else begin
      phase      <= phaseNxt;
      resetSeenQ <= rstHit;
    end
  end

  assign resetSeen = resetSeenQ;

  // R10
  drv_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    drvActive |-> (phase == PH_RSLOT || phase == PH_PDDRV));

  // R3
  rd_zero_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    txAck |=> (drvActive == !$past(txBit)));

  // R7
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PDDRV && !st.atPdLow) |=> drvActive);

  // R6
  rst_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetSeen |=> !resetSeen);

endmodule

// File: rtl/wire1_slave_phy.sv
module wire1_slave_phy
  import w1p_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_US   = 30,
  parameter int RD_HOLD_US  = 30,
  parameter int RST_US      = 450,
  parameter int PD_WAIT_US  = 30,
  parameter int PD_LOW_US   = 120
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineDrvLow,
  input  logic txReq,
  input  logic txBit,
  output logic txAck,
  output logic rxValid,
  output logic rxBit,
  output logic resetSeen
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int SAMPLE_CYC = SAMPLE_US  * CYC_PER_US;
  localparam int HOLD_CYC   = RD_HOLD_US * CYC_PER_US;
  localparam int RST_CYC    = RST_US     * CYC_PER_US;
  localparam int PDW_CYC    = PD_WAIT_US * CYC_PER_US;
  localparam int PDL_CYC    = PD_LOW_US  * CYC_PER_US;
  localparam int MAX_A      = (SAMPLE_CYC > HOLD_CYC) ? SAMPLE_CYC : HOLD_CYC;
  localparam int MAX_B      = (PDW_CYC > PDL_CYC) ? PDW_CYC : PDL_CYC;
  localparam int MAX_C      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC    = (MAX_C > RST_CYC) ? MAX_C : RST_CYC;
  localparam int TMR_W      = $clog2(MAX_CYC + 1);

  ctl_t  ctl;
  stat_t st;

  w1p_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .SAMPLE_CYC (SAMPLE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .RST_CYC    (RST_CYC),
    .PDW_CYC    (PDW_CYC),
    .PDL_CYC    (PDL_CYC),
    .TMR_W      (TMR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .lineIn    (lineIn),
    .ctl       (ctl),
    .st        (st),
    .lineDrvLow(lineDrvLow),
    .rxValid   (rxValid),
    .rxBit     (rxBit)
  );

  w1p_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .txReq    (txReq),
    .txBit    (txBit),
    .drvActive(lineDrvLow),
    .ctl      (ctl),
    .txAck    (txAck),
    .resetSeen(resetSeen)
  );

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txAck, rxValid, resetSeen}));

endmodule

// File: tb/tb_wire1_slave_phy.sv
`timescale 1ns/1ps
module tb_wire1_slave_phy;

  localparam int CLK_HZ   = 4_000_000;
  localparam int US       = CLK_HZ / 1_000_000;
  localparam int SMP_US   = 30;
  localparam int HOLD_US  = 30;
  localparam int RST_US   = 450;
  localparam int PDW_US   = 30;
  localparam int PDL_US   = 120;
  localparam int SLOT_US  = 70;
  localparam int SYNC_LAT = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, masterLow, txReq, txBit;
  logic lineIn, lineDrvLow, txAck, rxValid, rxBit, resetSeen;

  assign lineIn = !(masterLow || lineDrvLow);

  wire1_slave_phy #(
    .CLK_HZ(CLK_HZ), .SAMPLE_US(SMP_US), .RD_HOLD_US(HOLD_US),
    .RST_US(RST_US), .PD_WAIT_US(PDW_US), .PD_LOW_US(PDL_US)
  ) dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .lineDrvLow(lineDrvLow),
    .txReq(txReq), .txBit(txBit), .txAck(txAck), .rxValid(rxValid),
    .rxBit(rxBit), .resetSeen(resetSeen)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int rxCnt = 0, ackCnt = 0, rstCnt = 0, drvRises = 0;
  int lastRxCyc = 0, drvStartCyc = 0, drvLen = 0;
  logic lastRx = 1'b1, drvPrev = 1'b0;

  always @(negedge clk) begin
    if (rxValid) begin rxCnt++; lastRx = rxBit; lastRxCyc = cyc; end
    if (txAck) ackCnt++;
    if (resetSeen) rstCnt++;
    if (lineDrvLow && !drvPrev) begin drvRises++; drvStartCyc = cyc; end
    if (!lineDrvLow && drvPrev) drvLen = cyc - drvStartCyc;
    drvPrev = lineDrvLow;
  end

  int nChecks = 0, nErr = 0;
  bit done = 0;

  function automatic int expWriteBit(int lowUs);
    return (lowUs < SMP_US) ? 1 : 0;
  endfunction
  function automatic int expRxDelay();
    return SMP_US * US + SYNC_LAT;
  endfunction
  function automatic int expPdDelay();
    return PDW_US * US + SYNC_LAT;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkEq(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkNear(string req, string what, int act, int exp);
    nChecks++;
    if (act < exp - 1 || act > exp + 1) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeSlot(int lowUs, string req);
    int r0, a0, d0, fallCyc;
    r0 = rxCnt; a0 = ackCnt; d0 = drvRises;
    fallCyc = cyc;
    masterLow = 1'b1;
    tick(lowUs * US);
    masterLow = 1'b0;
    if (lowUs < SLOT_US) tick((SLOT_US - lowUs) * US);
    tick(3 * US);
    checkEq(req, "write slot bit count", rxCnt, r0 + 1);
    checkEq(req, "write slot bit value", int'(lastRx), expWriteBit(lowUs));
    checkNear(req, "sample delay", lastRxCyc - fallCyc, expRxDelay());
    checkEq("R10", "no drive in write slot", drvRises, d0);
    checkEq("R4", "no ack in write slot", ackCnt, a0);
  endtask

  task automatic readSlot(logic b);
    int r0, a0, d0;
    logic seen;
    r0 = rxCnt; a0 = ackCnt; d0 = drvRises;
    txBit = b; txReq = 1'b1;
    masterLow = 1'b1;
    tick(2 * US);
    masterLow = 1'b0;
    txReq = 1'b0;
    tick(11 * US);
    seen = lineIn;
    tick((SLOT_US - 13) * US);
    tick(3 * US);
    checkEq(b ? "R4" : "R3", "master read value", int'(seen), int'(b));
    checkEq(b ? "R4" : "R3", "ack count", ackCnt, a0 + 1);
    checkEq("R4", "no rx bit in read slot", rxCnt, r0);
    if (!b) begin
      checkEq("R3", "one drive pulse", drvRises, d0 + 1);
      checkNear("R3", "drive length", drvLen, HOLD_US * US);
    end else begin
      checkEq("R4", "no drive for 1", drvRises, d0);
    end
  endtask

  task automatic resetSeq(int lowUs, bit glitch);
    int rc, r0, d0, relCyc;
    rc = rstCnt; r0 = rxCnt; d0 = drvRises;
    masterLow = 1'b1;
    tick(lowUs * US);
    relCyc = cyc;
    masterLow = 1'b0;
    if (glitch) begin
      tick(10);
      masterLow = 1'b1;
      tick(8);
      masterLow = 1'b0;
    end
    tick((PDW_US + PDL_US + 40) * US);
    checkEq("R6", "reset strobe count", rstCnt, rc + 1);
    checkEq("R6", "bit reported inside reset low", rxCnt, r0 + 1);
    checkEq("R6", "that bit is 0", int'(lastRx), 0);
    checkEq("R7", "presence pulse count", drvRises, d0 + 1);
    checkNear("R7", "presence delay", drvStartCyc - relCyc, expPdDelay());
    checkNear("R7", "presence length", drvLen, PDL_US * US);
    if (glitch) checkEq("R9", "no bit from glitch", rxCnt, r0 + 1);
  endtask

  initial begin
    int rc, r0, a0, d0;
    rstN = 1'b0; masterLow = 1'b0; txReq = 1'b0; txBit = 1'b1;
    void'($urandom(32'd4711));
    tick(5);
    rstN = 1'b1;
    tick(20);
    // R1
    checkEq("R1", "drive after reset", int'(lineDrvLow), 0);
    checkEq("R1", "strobes after reset", rxCnt + ackCnt + rstCnt, 0);

    // R2 directed
    writeSlot(5, "R2");
    writeSlot(60, "R2");
    writeSlot(25, "R2");
    writeSlot(36, "R2");

    // R3 / R4 directed
    readSlot(1'b0);
    readSlot(1'b1);

    // R5: late request
    a0 = ackCnt; d0 = drvRises; r0 = rxCnt;
    masterLow = 1'b1;
    tick(4);
    masterLow = 1'b0;
    tick(20);
    txBit = 1'b0; txReq = 1'b1;
    tick((SLOT_US + 3) * US - 24);
    checkEq("R5", "late request not acked", ackCnt, a0);
    checkEq("R5", "late request no drive", drvRises, d0);
    checkEq("R5", "slot stayed write", rxCnt, r0 + 1);
    checkEq("R5", "write bit value", int'(lastRx), 1);
    readSlot(1'b0);

    // R6 / R7 / R9
    resetSeq(500, 1'b0);
    resetSeq(480, 1'b1);

    // R8: long lows below threshold
    rc = rstCnt; d0 = drvRises;
    writeSlot(120, "R8");
    writeSlot(400, "R8");
    tick((PDW_US + PDL_US) * US);
    checkEq("R8", "no reset for short lows", rstCnt, rc);
    checkEq("R8", "no presence for short lows", drvRises, d0);

    // Random mix
    for (int i = 0; i < 24; i++) begin
      if ($urandom_range(0, 1) == 0) begin
        int lowUs;
        lowUs = ($urandom_range(0, 1) == 0) ? int'($urandom_range(1, 25))
                                            : int'($urandom_range(36, 58));
        writeSlot(lowUs, "R2");
      end else begin
        readSlot(1'($urandom_range(0, 1)));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule